// File: doc/BRIEF.md
# I2C slave command interface for a power monitor

This block is the serial-bus target of a supply current and voltage monitor. It runs on a fast system clock that oversamples the two bus lines and filters them. Its bus address is set by two four-level strap codes. A bus master can send it four kinds of transaction:

- an address-only probe;
- a command byte that sets up the converter sequencing;
- a write to one of three alert setup registers;
- a read of the latest conversion results or of the alert status byte.

The converter sequencer and the alert logic sit outside this block. They read the command and setup registers from its outputs and supply the 12-bit results, the status byte and a one-shot busy flag on its inputs. The data line is modelled as a pull-down enable for an open-drain pad. On reads the block packs the two 12-bit results into a two- or three-byte frame, and it refuses reads while a one-shot conversion is still running.

Top module: `pmon_i2c_slave`

## Requirements
- R1: The 7-bit target address is {2'b01, 1'b1, a1, a0}, where a1 and a0 are the 2-bit strap codes, so the 8-bit address byte is 0x60 | a1<<3 | a0<<1. A byte carrying any other address gets no ACK and changes nothing.
- R2: An address byte with the write bit (bit 0 = 0) followed at once by a stop is acknowledged and leaves every register unchanged.
- R3: A first written byte with bit 7 = 0 loads its bits 6:0 into `cmd_o`, and `cmd_wr_o` is high for exactly one clock for each such byte.
- R4: A first written byte with bit 7 = 1 selects a setup register by its bits 1:0: 01 for alert enable, 10 for alert threshold, 11 for control. The next byte is stored there. Selector 00 stores nothing. The reset values are 0x04, 0xFF and 0x00.
- R5: When cmd bit 6 = 0 and both channels are on (voltage on = cmd[0]|cmd[1], current on = cmd[2]|cmd[3]), a read returns three bytes: V[11:4], I[11:4], then {V[3:0], I[3:0]}.
- R6: When exactly one channel is on, a read returns that channel's bits 11:4, then {bits 3:0, 4'b0000}. When no channel is on, the voltage layout is used.
- R7: When cmd bit 6 = 1, a read returns the status input as its only byte.
- R8: While `oneshot_busy_i` is high, a read address gets no ACK. Write addresses are still acknowledged.
- R9: Bytes requested past the end of the frame read as 0x00. After the master NACKs a byte, the block releases SDA.
- R10: A start or a stop inside a byte returns the block to idle. A register changes only after its byte has been fully received and acknowledged, so a selector byte followed by a stop writes nothing.
- R11: `sda_pull_o` changes only while SCL is low.
- R12: A pulse on either line that is shorter than the filter window is ignored, so a short SDA dip while SCL is high is not taken as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data pad |
| strap_a0_i | input | 2 | Strap code for address bits 1:0 (0 low, 1 resistor, 2 open, 3 high) |
| strap_a1_i | input | 2 | Strap code for address bits 3:2 |
| oneshot_busy_i | input | 1 | A one-shot conversion is still pending |
| volt_code_i | input | 12 | Latest voltage result |
| curr_code_i | input | 12 | Latest current result |
| status_i | input | 8 | Alert status byte |
| cmd_o | output | 7 | Command register |
| cmd_wr_o | output | 1 | One-clock pulse on each command byte write |
| alert_en_o | output | 8 | Alert enable register |
| alert_th_o | output | 8 | Alert threshold register |
| ctrl_o | output | 8 | Control register |

## Verification
Reads are run with random result codes under every channel setting: both channels, voltage only, current only, status mode and no channel. Each read asks for one byte more than the frame holds, which shows whether the nibbles are packed and the frame length is right. The address is tried over random strap codes against a one-bit-off neighbour, which separates address decode from plain acknowledgement. Directed cases cover:

- the NACK while a conversion is busy;
- transfers cut short by a repeated start or a stop inside a byte, and a selector byte sent with no data byte;
- an unused selector;
- an SDA glitch followed by a full address byte with no real start. A block that takes the glitch as a start would acknowledge that byte.

// File: rtl/pmon_i2c_pkg.sv
// Shared constants, link states and helper functions for the serial target.
// Assumes a 12-bit converter result split into an 8-bit high part and a 4-bit low part.
package pmon_i2c_pkg;

    localparam int CODE_W = 12;
    localparam int LO_W   = 4;
    localparam int HI_W   = CODE_W - LO_W;
    localparam int IDX_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } link_st_t;

    // Build the 7-bit target address from the two strap codes.
    function automatic logic [6:0] strap_addr(input logic [1:0] a1, input logic [1:0] a0);
        return {3'b011, a1, a0};
    endfunction

endpackage

// File: rtl/pmon_line_filter.sv
// Synchronizes one bus line and passes a new level on only after it has held
// for FILT_CYC clocks in a row. Assumes an idle-high line.
module pmon_line_filter #(
    parameter int FILT_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchronizer followed by a stability counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                line_o <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R12: the filtered level only ever takes the synchronized level.
    p_filt_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> (line_o == $past(sync_q[1])));

endmodule

// File: rtl/pmon_i2c_link.sv
// Bit- and byte-level bus engine. It detects start and stop, shifts bytes in
// and out, drives the ACK and NACK, and reports completed write bytes.
// Assumes filtered, synchronized line levels.
module pmon_i2c_link
    import pmon_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [6:0]       dev_addr,
    input  logic             busy_i,
    input  logic [7:0]       tx_byte_i,
    output logic             sda_pull_o,
    output logic [7:0]       rx_byte_o,
    output logic             rx_commit_o,
    output logic [IDX_W-1:0] rx_idx_o,
    output logic             rd_load_o,
    output logic [IDX_W-1:0] rd_idx_o
);
    link_st_t         state_q;
    logic             scl_q, sda_q;
    logic [3:0]       bitcnt_q;
    logic [7:0]       sh_q;
    logic             rw_q, mack_q;
    logic [IDX_W-1:0] wr_idx_q;

    logic scl_rise, scl_fall, start_det, stop_det, addr_hit;

    // Line edges and bus conditions.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
        addr_hit  = (sh_q[7:1] == dev_addr) && !(sh_q[0] && busy_i);
    end

    assign rx_byte_o = sh_q;

    // Protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            scl_q       <= 1'b1;
            sda_q       <= 1'b1;
            bitcnt_q    <= '0;
            sh_q        <= '0;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
            wr_idx_q    <= '0;
            rd_idx_o    <= '0;
            rx_idx_o    <= '0;
            rx_commit_o <= 1'b0;
            rd_load_o   <= 1'b0;
            sda_pull_o  <= 1'b0;
        end else begin
            scl_q       <= scl_f;
            sda_q       <= sda_f;
            rx_commit_o <= 1'b0;
            rd_load_o   <= 1'b0;
            if (start_det) begin
                state_q    <= ST_ADDR;
                bitcnt_q   <= '0;
                wr_idx_q   <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_det) begin
                state_q    <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_WBYTE: begin
                        if (scl_rise) begin
                            sh_q     <= {sh_q[6:0], sda_f};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            if (state_q == ST_WBYTE) begin
                                sda_pull_o <= 1'b1;
                                state_q    <= ST_WACK;
                            end else if (addr_hit) begin
                                sda_pull_o <= 1'b1;
                                rw_q       <= sh_q[0];
                                rd_load_o  <= sh_q[0];
                                rd_idx_o   <= '0;
                                state_q    <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                sh_q       <= tx_byte_i;
                                sda_pull_o <= ~tx_byte_i[7];
                                state_q    <= ST_RBYTE;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state_q    <= ST_WBYTE;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_pull_o  <= 1'b0;
                            rx_commit_o <= 1'b1;
                            rx_idx_o    <= wr_idx_q;
                            if (wr_idx_q != '1) wr_idx_q <= wr_idx_q + 1'b1;
                            bitcnt_q    <= '0;
                            state_q     <= ST_WBYTE;
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_rise) begin
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt_q == 4'd8) begin
                                sda_pull_o <= 1'b0;
                                state_q    <= ST_RACK;
                            end else begin
                                sh_q       <= {sh_q[6:0], 1'b0};
                                sda_pull_o <= ~sh_q[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                            if (!sda_f && rd_idx_o != '1) rd_idx_o <= rd_idx_o + 1'b1;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                bitcnt_q   <= '0;
                                sh_q       <= tx_byte_i;
                                sda_pull_o <= ~tx_byte_i[7];
                                state_q    <= ST_RBYTE;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the pull-down changes only while the filtered SCL is low.
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_f));

    // R8: a read address that arrives while busy is not acknowledged.
    p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && scl_fall && bitcnt_q == 4'd8 && sh_q[0] && busy_i && !start_det && !stop_det)
        |=> !sda_pull_o);

    // R9: the line is released whenever the engine is idle.
    p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull_o);

endmodule

// File: rtl/pmon_cmd_regs.sv
// Command and setup register file. It is written only by committed,
// acknowledged bytes from the link. Byte index 0 is a command byte or a
// selector byte; byte index 1 is setup register data.
module pmon_cmd_regs
    import pmon_i2c_pkg::*;
#(
    parameter logic [7:0] EN_RST   = 8'h04,
    parameter logic [7:0] TH_RST   = 8'hFF,
    parameter logic [7:0] CTRL_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       byte_i,
    output logic [6:0]       cmd_o,
    output logic             cmd_wr_o,
    output logic [7:0]       alert_en_o,
    output logic [7:0]       alert_th_o,
    output logic [7:0]       ctrl_o
);
    logic [1:0] sel_q;

    // Decode committed bytes into register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= 2'b00;
            cmd_o      <= '0;
            cmd_wr_o   <= 1'b0;
            alert_en_o <= EN_RST;
            alert_th_o <= TH_RST;
            ctrl_o     <= CTRL_RST;
        end else begin
            cmd_wr_o <= 1'b0;
            if (commit_i && idx_i == '0) begin
                if (!byte_i[7]) begin
                    cmd_o    <= byte_i[6:0];
                    cmd_wr_o <= 1'b1;
                    sel_q    <= 2'b00;
                end else begin
                    sel_q <= byte_i[1:0];
                end
            end else if (commit_i && idx_i == IDX_W'(1)) begin
                case (sel_q)
                    2'b01:   alert_en_o <= byte_i;
                    2'b10:   alert_th_o <= byte_i;
                    2'b11:   ctrl_o     <= byte_i;
                    default: ;
                endcase
            end
        end
    end

    // R3: the command strobe lasts a single clock.
    p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_o |=> !cmd_wr_o);

    // R4: the threshold changes only on a committed second byte.
    p_th_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alert_th_o) |-> ($past(commit_i) && $past(idx_i) == IDX_W'(1)));

    // R10: no setup register moves without a commit.
    p_no_commit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit_i) |-> ($stable(alert_en_o) && $stable(ctrl_o) && $stable(cmd_o)));

endmodule

// File: rtl/pmon_read_frame.sv
// Takes a snapshot of the results and the frame mode when a read is accepted,
// then gives the byte for each position of the read frame.
module pmon_read_frame
    import pmon_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              stat_mode_i,
    input  logic              v_on_i,
    input  logic              i_on_i,
    input  logic [CODE_W-1:0] volt_i,
    input  logic [CODE_W-1:0] curr_i,
    input  logic [7:0]        status_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [7:0]        byte_o
);
    logic [CODE_W-1:0] v_q, i_q, one_q;
    logic [7:0]        st_q;
    logic              stat_q, both_q;

    // Snapshot when the read address is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0; i_q <= '0; one_q <= '0; st_q <= '0;
            stat_q <= 1'b0; both_q <= 1'b0;
        end else if (load_i) begin
            v_q    <= volt_i;
            i_q    <= curr_i;
            one_q  <= (i_on_i && !v_on_i) ? curr_i : volt_i;
            st_q   <= status_i;
            stat_q <= stat_mode_i;
            both_q <= v_on_i && i_on_i;
        end
    end

    // Select the byte for this frame position.
    always_comb begin
        byte_o = 8'h00;
        if (stat_q) begin
            if (idx_i == '0) byte_o = st_q;
        end else if (both_q) begin
            case (idx_i)
                2'd0:    byte_o = v_q[CODE_W-1:LO_W];
                2'd1:    byte_o = i_q[CODE_W-1:LO_W];
                2'd2:    byte_o = {v_q[LO_W-1:0], i_q[LO_W-1:0]};
                default: byte_o = 8'h00;
            endcase
        end else begin
            case (idx_i)
                2'd0:    byte_o = one_q[CODE_W-1:LO_W];
                2'd1:    byte_o = {one_q[LO_W-1:0], {(HI_W-LO_W){1'b0}}};
                default: byte_o = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/pmon_i2c_slave.sv
// Top of the serial target: two line filters, the protocol engine, the
// register file and the read-frame builder. Assumes the strap codes are static
// while a transfer is in progress.
module pmon_i2c_slave
    import pmon_i2c_pkg::*;
#(
    parameter int         FILT_CYC = 12,
    parameter logic [7:0] EN_RST   = 8'h04,
    parameter logic [7:0] TH_RST   = 8'hFF,
    parameter logic [7:0] CTRL_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [1:0]        strap_a0_i,
    input  logic [1:0]        strap_a1_i,
    input  logic              oneshot_busy_i,
    input  logic [CODE_W-1:0] volt_code_i,
    input  logic [CODE_W-1:0] curr_code_i,
    input  logic [7:0]        status_i,
    output logic [6:0]        cmd_o,
    output logic              cmd_wr_o,
    output logic [7:0]        alert_en_o,
    output logic [7:0]        alert_th_o,
    output logic [7:0]        ctrl_o
);
    logic [1:0]       raw_lines, flt_lines;
    logic [7:0]       rx_byte, tx_byte;
    logic             rx_commit, rd_load;
    logic [IDX_W-1:0] rx_idx, rd_idx;

    assign raw_lines = {sda_i, scl_i};

    // One identical filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_flt
        pmon_line_filter #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(flt_lines[g])
        );
    end

    pmon_i2c_link u_link (
        .clk(clk), .rst_n(rst_n),
        .scl_f(flt_lines[0]), .sda_f(flt_lines[1]),
        .dev_addr(strap_addr(strap_a1_i, strap_a0_i)),
        .busy_i(oneshot_busy_i), .tx_byte_i(tx_byte),
        .sda_pull_o(sda_pull_o), .rx_byte_o(rx_byte),
        .rx_commit_o(rx_commit), .rx_idx_o(rx_idx),
        .rd_load_o(rd_load), .rd_idx_o(rd_idx)
    );

    pmon_cmd_regs #(.EN_RST(EN_RST), .TH_RST(TH_RST), .CTRL_RST(CTRL_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .commit_i(rx_commit), .idx_i(rx_idx), .byte_i(rx_byte),
        .cmd_o(cmd_o), .cmd_wr_o(cmd_wr_o),
        .alert_en_o(alert_en_o), .alert_th_o(alert_th_o), .ctrl_o(ctrl_o)
    );

    pmon_read_frame u_frame (
        .clk(clk), .rst_n(rst_n), .load_i(rd_load),
        .stat_mode_i(cmd_o[6]),
        .v_on_i(cmd_o[0] | cmd_o[1]),
        .i_on_i(cmd_o[2] | cmd_o[3]),
        .volt_i(volt_code_i), .curr_i(curr_code_i), .status_i(status_i),
        .idx_i(rd_idx), .byte_o(tx_byte)
    );

endmodule

// File: tb/sim_pmon_i2c_slave.sv
`timescale 1ns/100ps
module sim_pmon_i2c_slave;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull;
    logic [1:0] a0 = 2'd0, a1 = 2'd0;
    logic busy = 1'b0;
    logic [11:0] vcode = '0, icode = '0;
    logic [7:0] stat = '0;
    logic [6:0] cmd;
    logic cmd_wr;
    logic [7:0] en, th, ctrl;
    logic sda_line;
    int checks = 0, errors = 0, wr_pulses = 0, r11_viol = 0;
    logic pull_d = 1'b0;
    logic done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #2.5 clk = ~clk;

    pmon_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .strap_a0_i(a0), .strap_a1_i(a1), .oneshot_busy_i(busy),
        .volt_code_i(vcode), .curr_code_i(icode), .status_i(stat),
        .cmd_o(cmd), .cmd_wr_o(cmd_wr), .alert_en_o(en), .alert_th_o(th), .ctrl_o(ctrl)
    );

    // Monitors: command strobe cycles and pull changes while SCL is high (R11).
    always @(negedge clk) begin
        if (cmd_wr) wr_pulses++;
        if (rst_n && sda_pull !== pull_d && scl_m) r11_viol++;
        pull_d = sda_pull;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(2*H); sda_m = 1'b0; wt(2*H); scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(2*H); sda_m = 1'b1; wt(2*H);
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        sda_m = b; wt(H); scl_m = 1'b1; wt(2*H); r = sda_line; scl_m = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int k = 7; k >= 0; k--) xfer_bit(d[k], r);
        xfer_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic r;
        for (int k = 0; k < 8; k++) begin
            xfer_bit(1'b1, r);
            d = {d[6:0], r};
        end
        xfer_bit(~mack, r);
    endtask

    // n data bytes (0..2) after a write address, then stop.
    task automatic wr_txn(input logic [6:0] a, input int n, input logic [7:0] b0, input logic [7:0] b1,
                          output logic aack, output logic dack);
        logic k;
        dack = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, aack);
        if (aack && n > 0) begin send_byte(b0, k); dack &= k; end
        if (aack && n > 1) begin send_byte(b1, k); dack &= k; end
        bus_stop();
    endtask

    // Four-byte read, last byte NACKed; rel = SDA released after that NACK.
    task automatic rd_txn(input logic [6:0] a, output logic aack, output logic [31:0] d, output logic rel);
        logic [7:0] b;
        d = '0; rel = 1'b1;
        bus_start();
        send_byte({a, 1'b1}, aack);
        if (aack) begin
            for (int k = 0; k < 4; k++) begin
                recv_byte(k != 3, b);
                d = {d[23:0], b};
            end
            rel = ~sda_pull;
        end
        bus_stop();
    endtask

    function automatic logic [6:0] addr_of(input logic [1:0] s1, input logic [1:0] s0);
        return 7'h30 | 7'({s1, 2'b00}) | 7'(s0);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [6:0] c, input logic [11:0] v, input logic [11:0] i,
                                            input logic [7:0] s, input int k);
        logic von, ion;
        logic [11:0] one;
        if (c[6]) return (k == 0) ? s : 8'h00;
        von = c[0] | c[1];
        ion = c[2] | c[3];
        if (von && ion) begin
            if (k == 0) return v[11:4];
            if (k == 1) return i[11:4];
            if (k == 2) return {v[3:0], i[3:0]};
            return 8'h00;
        end
        one = (ion && !von) ? i : v;
        if (k == 0) return one[11:4];
        if (k == 1) return {one[3:0], 4'h0};
        return 8'h00;
    endfunction

    // Watchdog: an expired run is a failed check and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic aa, da, rel, r;
        logic [31:0] rd;
        logic [6:0] ad, c;
        logic [7:0] e;
        int p0, seed;
        seed = $urandom(32'h5eed1);

        wt(10); rst_n = 1'b1; wt(5);
        // Reset state (R4 reset values, R3 command, R11 released line).
        chk(cmd == 7'h00, "R3 reset cmd", cmd, 0);
        chk(en == 8'h04 && th == 8'hFF && ctrl == 8'h00, "R4 reset values", {en, th, ctrl}, 24'h04FF00);
        chk(sda_pull == 1'b0, "R11 reset release", sda_pull, 0);

        // R1/R2: random straps, right and one-bit-off addresses.
        for (int it = 0; it < 5; it++) begin
            a0 = 2'($urandom); a1 = 2'($urandom); wt(4);
            ad = addr_of(a1, a0);
            wr_txn(ad, 0, 8'h00, 8'h00, aa, da);
            chk(aa, "R1 own address acked", aa, 1);
            chk(cmd == 7'h00 && en == 8'h04 && th == 8'hFF, "R2 quick cmd no change", {cmd, en, th}, 0);
            wr_txn(ad ^ (7'h1 << ($urandom % 4)), 1, 8'h05, 8'h00, aa, da);
            chk(!aa && cmd == 7'h00, "R1 foreign address ignored", {aa, cmd}, 0);
        end
        ad = addr_of(a1, a0);

        // R3: command byte and its strobe.
        p0 = wr_pulses;
        wr_txn(ad, 1, 8'h15, 8'h00, aa, da);
        chk(aa && da && cmd == 7'h15, "R3 command load", cmd, 8'h15);
        chk(wr_pulses == p0 + 1, "R3 single strobe", wr_pulses - p0, 1);

        // R4: setup registers and the unused selector.
        wr_txn(ad, 2, 8'h81, 8'h3A, aa, da);
        chk(en == 8'h3A, "R4 alert enable", en, 8'h3A);
        wr_txn(ad, 2, 8'h82, 8'h55, aa, da);
        chk(th == 8'h55, "R4 alert threshold", th, 8'h55);
        wr_txn(ad, 2, 8'h83, 8'h01, aa, da);
        chk(ctrl == 8'h01, "R4 control", ctrl, 1);
        wr_txn(ad, 2, 8'h80, 8'h77, aa, da);
        chk(en == 8'h3A && th == 8'h55 && ctrl == 8'h01 && cmd == 7'h15, "R4 selector 00 ignored",
            {en, th, ctrl}, 24'h3A5501);

        // R5/R6/R7/R9: random results under every channel setting.
        for (int it = 0; it < 12; it++) begin
            case ($urandom % 5)
                0: c = 7'h05;
                1: c = 7'h01;
                2: c = 7'h04;
                3: c = 7'h40 | 7'($urandom % 32);
                default: c = 7'h10;
            endcase
            if (it < 5) c = (it == 0) ? 7'h0A : (it == 1) ? 7'h02 : (it == 2) ? 7'h08 : (it == 3) ? 7'h4F : 7'h00;
            wr_txn(ad, 1, {1'b0, c}, 8'h00, aa, da);
            vcode = 12'($urandom); icode = 12'($urandom); stat = 8'($urandom);
            wt(4);
            rd_txn(ad, aa, rd, rel);
            chk(aa, "R8 read acked when idle", aa, 1);
            for (int k = 0; k < 4; k++) begin
                e = exp_byte(c, vcode, icode, stat, k);
                chk(rd[31-8*k -: 8] == e,
                    c[6] ? "R7 status frame" : ((c[0]|c[1]) && (c[2]|c[3])) ? "R5 three-byte frame"
                    : (k > 1 ? "R9 past frame end" : "R6 two-byte frame"),
                    rd[31-8*k -: 8], e);
            end
            chk(rel, "R9 release after NACK", rel, 1);
        end

        // R8: busy refuses reads but not writes.
        busy = 1'b1; wt(4);
        rd_txn(ad, aa, rd, rel);
        chk(!aa, "R8 read NACK while busy", aa, 0);
        wr_txn(ad, 1, 8'h05, 8'h00, aa, da);
        chk(aa && cmd == 7'h05, "R8 write acked while busy", {aa, cmd}, 8'h85);
        busy = 1'b0; wt(4);

        // R10: selector then stop writes nothing.
        wr_txn(ad, 1, 8'h82, 8'h00, aa, da);
        chk(th == 8'h55, "R10 selector without data", th, 8'h55);
        // R10: repeated start inside the data byte.
        bus_start();
        send_byte({ad, 1'b0}, aa);
        send_byte(8'h81, da);
        for (int k = 0; k < 4; k++) xfer_bit(1'b0, r);
        bus_start();
        send_byte({ad, 1'b0}, aa);
        bus_stop();
        chk(aa && en == 8'h3A, "R10 repeated start mid byte", en, 8'h3A);
        // R10: stop inside a command byte.
        bus_start();
        send_byte({ad, 1'b0}, aa);
        for (int k = 0; k < 3; k++) xfer_bit(1'b0, r);
        bus_stop();
        chk(cmd == 7'h05, "R10 stop mid byte", cmd, 5);

        // R12: short SDA dip with SCL high is no start.
        sda_m = 1'b0; wt(5); sda_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(H);
        send_byte({ad, 1'b0}, aa);
        bus_stop();
        chk(!aa, "R12 glitch not a start", aa, 0);
        wr_txn(ad, 0, 8'h00, 8'h00, aa, da);
        chk(aa, "R12 normal start after glitch", aa, 1);

        chk(r11_viol == 0, "R11 pull only while SCL low", r11_viol, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule